// File: doc/BRIEF.md
# Range Cache Maintenance Engine

The engine cleans and invalidates every cache line that touches a programmed span of physical memory. Software writes a 64-bit start address and a 64-bit length through a 32-bit register bus. It then writes the control register with the enable bit set. The engine walks the span one 128-byte granule at a time, in ascending order. For each granule it sends one request on a lookup port and waits for that port's acknowledge before it moves on. After the last granule is acknowledged, hardware clears the enable bit, so software polls that bit to learn that the work is finished.

An acknowledge always means success. A granule whose line is absent, or that belongs to another agent, is simply acknowledged and counted as done. The lookup port carries the operation code taken from the control register. Code 1 means clean and invalidate.

The walker is a three-state machine:
- **W_IDLE** waits for a start. On a start (transition *launch*) it loads the first and last granule indices and moves to W_REQ.
- **W_REQ** holds the request until the acknowledge arrives (transition *granted*), then moves to W_STEP.
- **W_STEP** either returns to W_IDLE with a done pulse when the last granule has been served (transition *finish*), or advances to the next granule and goes back to W_REQ (transition *advance*).

Top module: `cmaint_engine`

## Requirements
- R1: After reset the control register reads 0 and no lookup request is raised.
- R2: The register map is:
  - control at 0x5004: bit 0 is enable/busy, bit 1 is range mode, bits 3:2 are the operation code;
  - start address: low word at 0x5008, high word at 0x500C;
  - length: low word at 0x5010, high word at 0x5014.
  
  Written values read back unchanged, and any other offset reads 0.
- R3: The length register holds the byte count minus one, so the byte at start+length is included. Each 128-byte granule holding any byte of the span is requested exactly once, in ascending address order.
- R4: The start address is aligned down to a 128-byte boundary. An unaligned span that crosses a granule edge therefore requests both granules.
- R5: Writing the control register with bit 0 set while idle starts a walk. Bit 0 then reads 1 until the cycle after the last acknowledge, when hardware clears it.
- R6: A request stays asserted with a stable address until it is acknowledged. The next request comes no earlier than one cycle after that acknowledge.
- R7: While busy, writes to the start and length registers are ignored.
- R8: While busy, writes to the control register are ignored. They can neither stop the walk nor change its mode or code.
- R9: With range mode clear (bit 1 = 0), only the granule containing the start address is requested.
- R10: The lookup port's operation output carries control bits 3:2 during every request.
- R11: Writing the control register with bit 0 clear while idle stores the mode and code but starts no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 16 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| lkp_req | output | 1 | Maintenance request for one granule |
| lkp_addr | output | 64 | Granule base address (128-byte aligned) |
| lkp_op | output | 2 | Operation code of the running walk |
| lkp_ack | input | 1 | Granule served (present or not, owned or not) |

## Verification
A walker counter that is off by one shows up at the lookup port within a single granule period, as a missing or extra request at either end of the span. A corrupted end index does the same. A state machine that drops back to idle early, or that never reaches the finish transition, shows up as a busy bit that clears while requests are still expected or that never clears. Loss of the busy lock becomes visible on the next register read, because the stored address, length or mode changes during a walk.

// File: rtl/cme_pkg.sv
package cme_pkg;
    typedef enum logic [1:0] {
        W_IDLE,
        W_REQ,
        W_STEP
    } walk_state_t;

    localparam logic [15:0] OFS_CTRL     = 16'h5004;
    localparam logic [15:0] OFS_START_LO = 16'h5008;
    localparam logic [15:0] OFS_START_HI = 16'h500C;
    localparam logic [15:0] OFS_LEN_LO   = 16'h5010;
    localparam logic [15:0] OFS_LEN_HI   = 16'h5014;
endpackage

// File: rtl/cme_regs.sv
module cme_regs
    import cme_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BUS_AW = 16,
    localparam int WIDE_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [BUS_AW-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              walk_done,
    output logic              go,
    output logic [WIDE_W-1:0] start_q,
    output logic [WIDE_W-1:0] len_q,
    output logic              range_q,
    output logic [1:0]        op_q,
    output logic              busy
);
    logic en_q;

    assign busy = en_q;
    assign go   = wr && !en_q && (addr == BUS_AW'(OFS_CTRL)) && wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            range_q <= 1'b0;
            op_q    <= '0;
            start_q <= '0;
            len_q   <= '0;
        end else begin
            if (walk_done) begin
                en_q <= 1'b0;
            end
            if (wr && !en_q) begin
                unique case (addr)
                    BUS_AW'(OFS_CTRL): begin
                        en_q    <= wdata[0];
                        range_q <= wdata[1];
                        op_q    <= wdata[3:2];
                    end
                    BUS_AW'(OFS_START_LO): start_q[DATA_W-1:0]      <= wdata;
                    BUS_AW'(OFS_START_HI): start_q[WIDE_W-1:DATA_W] <= wdata;
                    BUS_AW'(OFS_LEN_LO):   len_q[DATA_W-1:0]        <= wdata;
                    BUS_AW'(OFS_LEN_HI):   len_q[WIDE_W-1:DATA_W]   <= wdata;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            BUS_AW'(OFS_CTRL):     rdata = DATA_W'({op_q, range_q, en_q});
            BUS_AW'(OFS_START_LO): rdata = start_q[DATA_W-1:0];
            BUS_AW'(OFS_START_HI): rdata = start_q[WIDE_W-1:DATA_W];
            BUS_AW'(OFS_LEN_LO):   rdata = len_q[DATA_W-1:0];
            BUS_AW'(OFS_LEN_HI):   rdata = len_q[WIDE_W-1:DATA_W];
            default:               rdata = '0;
        endcase
    end

    // R5: the done pulse always clears the busy flag
    a_r5_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !busy);
    // R7: address and length stay frozen while busy
    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(start_q) && $stable(len_q)));
    // R8: mode and code stay frozen, and busy cannot be dropped by software
    a_r8_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !walk_done) |=> (busy && $stable(range_q) && $stable(op_q)));
endmodule

// File: rtl/cme_walker.sv
module cme_walker
    import cme_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int GRAN_BYTES = 128,
    localparam int GRAN_LSB  = $clog2(GRAN_BYTES),
    localparam int IDX_W     = ADDR_W - GRAN_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] len_m1,
    input  logic              range_mode,
    output logic              done,
    output logic              lkp_req,
    output logic [ADDR_W-1:0] lkp_addr,
    input  logic              lkp_ack
);
    walk_state_t state, nxt;
    logic [IDX_W-1:0] cur_idx, last_idx;
    logic [ADDR_W-1:0] end_addr;
    logic              at_last;

    assign end_addr = start_addr + len_m1;
    assign at_last  = (cur_idx == last_idx);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= W_IDLE;
            cur_idx  <= '0;
            last_idx <= '0;
        end else begin
            state <= nxt;
            if (state == W_IDLE && go) begin
                cur_idx  <= start_addr[ADDR_W-1:GRAN_LSB];
                last_idx <= range_mode ? end_addr[ADDR_W-1:GRAN_LSB]
                                       : start_addr[ADDR_W-1:GRAN_LSB];
            end else if (state == W_STEP && !at_last) begin
                cur_idx <= cur_idx + 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            W_IDLE: if (go)      nxt = W_REQ;   // launch
            W_REQ:  if (lkp_ack) nxt = W_STEP;  // granted
            W_STEP: nxt = at_last ? W_IDLE      // finish
                                  : W_REQ;      // advance
            default: nxt = W_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        lkp_req  = (state == W_REQ);
        done     = (state == W_STEP) && at_last;
        lkp_addr = {cur_idx, {GRAN_LSB{1'b0}}};
    end

    // R6: an unacknowledged request is held with a stable address
    a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req && !lkp_ack) |=> (lkp_req && $stable(lkp_addr)));
    // R6: a gap cycle follows every acknowledge
    a_r6_gap_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req && lkp_ack) |=> !lkp_req);
    // R3: successive requests move up by exactly one granule
    a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (state == W_STEP && !at_last) |=> (lkp_req && lkp_addr == $past(lkp_addr) + ADDR_W'(GRAN_BYTES)));
endmodule

// File: rtl/cmaint_engine.sv
module cmaint_engine
    import cme_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int BUS_AW     = 16,
    parameter int GRAN_BYTES = 128,
    localparam int ADDR_W    = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              lkp_req,
    output logic [ADDR_W-1:0] lkp_addr,
    output logic [1:0]        lkp_op,
    input  logic              lkp_ack
);
    logic              go, walk_done, range_q, busy;
    logic [1:0]        op_q;
    logic [ADDR_W-1:0] start_q, len_q;

    cme_regs #(.DATA_W(DATA_W), .BUS_AW(BUS_AW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
        .walk_done(walk_done), .go(go),
        .start_q(start_q), .len_q(len_q), .range_q(range_q), .op_q(op_q),
        .busy(busy)
    );

    cme_walker #(.ADDR_W(ADDR_W), .GRAN_BYTES(GRAN_BYTES)) u_walker (
        .clk(clk), .rst_n(rst_n),
        .go(go), .start_addr(bus_wdata_start(start_q)), .len_m1(len_q),
        .range_mode(bus_wdata[1]), .done(walk_done),
        .lkp_req(lkp_req), .lkp_addr(lkp_addr), .lkp_ack(lkp_ack)
    );

    function automatic logic [ADDR_W-1:0] bus_wdata_start(input logic [ADDR_W-1:0] s);
        return s;
    endfunction

    assign lkp_op = op_q;

    // R10: the code on the port does not change during a walk
    a_r10_op_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (lkp_req && $past(busy)) |-> $stable(lkp_op));
    // R5: a request is only raised while the busy bit is set
    a_r5_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_req |-> busy);
endmodule

// File: tb/test_cmaint_engine.sv
`timescale 1ns/1ps
module test_cmaint_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        lkp_req;
    logic [63:0] lkp_addr;
    logic [1:0]  lkp_op;
    logic        lkp_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    int ack_dly = 0;
    logic [63:0] exp_q[$];
    logic [1:0]  exp_op = '0;

    always #2.5 clk = ~clk;

    cmaint_engine i_cmaint_engine (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lkp_req(lkp_req),
        .lkp_addr(lkp_addr), .lkp_op(lkp_op), .lkp_ack(lkp_ack)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    // driver: push expected granules, program, start
    task automatic launch(input logic [63:0] s, input logic [63:0] l,
                          input logic rng, input logic [1:0] op);
        logic [63:0] first, last;
        first = s >> 7;
        last  = rng ? ((s + l) >> 7) : first;
        for (logic [63:0] g = first; g <= last; g++) exp_q.push_back(g << 7);
        exp_op = op;
        wr(16'h5008, s[31:0]);  wr(16'h500C, s[63:32]);
        wr(16'h5010, l[31:0]);  wr(16'h5014, l[63:32]);
        wr(16'h5004, {28'd0, op, rng, 1'b1});
    endtask

    task automatic wait_idle(input string req);
        logic [31:0] v;
        int n = 0;
        do begin rd(16'h5004, v); n++; end while (v[0] && n < 2000);
        check(req, {63'd0, v[0]}, 64'd0);
        check(req, 64'(exp_q.size()), 64'd0);
        exp_q.delete();
    endtask

    // monitor / lookup stub: compare each request against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (lkp_req && !lkp_ack) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R3 unexpected request actual=%h expected=none", lkp_addr);
                end else begin
                    check("R3/R4 granule order", lkp_addr, exp_q.pop_front());
                    check("R10 op code", 64'(lkp_op), 64'(exp_op));
                end
                repeat (ack_dly) @(negedge clk);
                check("R6 request held", {63'd0, lkp_req}, 64'd1);
                lkp_ack = 1'b1;
                @(negedge clk);
                lkp_ack = 1'b0;
                check("R6 gap after ack", {63'd0, lkp_req}, 64'd0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1
        rd(16'h5004, v); check("R1 ctrl reset", 64'(v), 64'd0);
        check("R1 no request", {63'd0, lkp_req}, 64'd0);
        // R2
        wr(16'h5008, 32'hDEAD_BE80); wr(16'h500C, 32'h0000_0012);
        wr(16'h5010, 32'h1234_5678); wr(16'h5014, 32'h0000_0009);
        rd(16'h5008, v); check("R2 start lo", 64'(v), 64'hDEAD_BE80);
        rd(16'h500C, v); check("R2 start hi", 64'(v), 64'h12);
        rd(16'h5010, v); check("R2 len lo", 64'(v), 64'h1234_5678);
        rd(16'h5014, v); check("R2 len hi", 64'(v), 64'h9);
        rd(16'h5018, v); check("R2 unmapped", 64'(v), 64'd0);
        // R11: store mode/code without starting
        wr(16'h5004, 32'h6);
        rd(16'h5004, v); check("R11 ctrl stored", 64'(v), 64'h6);
        repeat (5) @(negedge clk);
        check("R11 no request", {63'd0, lkp_req}, 64'd0);
        // R3: exactly one granule
        launch(64'h1000, 64'h7F, 1'b1, 2'd1); wait_idle("R3 one granule");
        // R3: one byte more spills into the next granule
        launch(64'h1000, 64'h80, 1'b1, 2'd1); wait_idle("R3 two granules");
        // R4: unaligned start crossing an edge
        ack_dly = 2;
        launch(64'h1_0000_107F, 64'h1, 1'b1, 2'd1); wait_idle("R4 unaligned");
        // R9: single granule mode
        launch(64'h2345, 64'hFFF, 1'b0, 2'd1); wait_idle("R9 single granule");
        // R10: other code
        ack_dly = 0;
        launch(64'h4000, 64'h17F, 1'b1, 2'd2); wait_idle("R10 code 2");
        // R5, R7, R8: long walk with slow acks and writes while busy
        ack_dly = 3;
        launch(64'h0, 64'h7FF, 1'b1, 2'd1);
        rd(16'h5004, v); check("R5 busy set", 64'(v), 64'h7);
        wr(16'h5004, 32'h0);
        wr(16'h5008, 32'hFFFF_FF00);
        wr(16'h5010, 32'h0);
        rd(16'h5004, v); check("R8 ctrl write ignored", 64'(v), 64'h7);
        rd(16'h5008, v); check("R7 start write ignored", 64'(v), 64'h0);
        rd(16'h5010, v); check("R7 len write ignored", 64'(v), 64'h7FF);
        wait_idle("R5 busy clears after 16 granules");
        repeat (5) @(negedge clk);
        check("R5 idle afterwards", {63'd0, lkp_req}, 64'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule